// File: doc/BRIEF.md
# MDIO Management Master

A clause-22 management master that talks to external PHY devices over a two-wire management bus: a clock output (MDC) and one bidirectional data line. Software writes a single packed command word (opcode, PHY address, register address, write data) into a 32-bit register and sets a start bit in that same write. The block then serializes the frame onto the data line and returns read data in the low half of the same register. The start bit reads back as a busy flag and clears by itself when the frame ends.

MDC is derived from the block clock through a 6-bit divider: the management clock runs at f_clk / (2·(N+1)), idles high between frames, and the master moves the data line only after MDC falls. It samples read data on the rising edge. For reads the master releases the line from the first turnaround bit through the last data bit. A device that fails to pull the second turnaround bit low sets a read-fail flag. The 32-bit preamble of ones can be skipped for devices that accept short frames. The data line is brought out as separate output, output-enable and input pins for an external pad.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register (offset 0x0) reads 0x00000000, the configuration register (offset 0x4) reads 0x00000041 (clause-22 bit set, divider 4), MDC is high and the data-line output enable is low.
- R2: While a frame runs, MDC has a period of 2·(N+1) clock cycles, where N is configuration bits 9:4. MDC stays high whenever no frame runs.
- R3: A command written with bit 29 set and opcode bits 27:26 = 01 sends 32 ones, then 01, the opcode, the PHY address (bits 25:21), the register address (bits 20:16), turnaround 10 and the 16 data bits (bits 15:0), each field MSB first. This is 64 MDC rising edges in total.
- R4: With configuration bit 12 set, the 32 preamble ones are left out and a frame is 32 MDC rising edges long.
- R5: Command bit 29 reads 1 from the cycle after the starting write until the frame ends, then reads 0.
- R6: For opcode 10 (read) the master disables its output from the first turnaround bit through the last data bit, and the 16 bits sampled on MDC rising edges during the data phase appear MSB first in command bits 15:0 when the frame ends.
- R7: Command bit 28 (read fail) is set at the end of a read if the second turnaround bit is sampled as 1. It is cleared at the end of a read where that bit is sampled as 0, and it is cleared when a new frame starts.
- R8: While bit 29 reads 1, writes to the command register and to the configuration register change nothing and start no frame.
- R9: While the output is enabled, the data-line output changes only on the clock edge where MDC falls.
- R10: Configuration bit 0 (clause-22 select), bits 9:4 (divider) and bit 12 (preamble skip) read back as written. All other configuration bits read 0, and command bits 31:30 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Byte offset: 0x0 command, 0x4 configuration |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |

## Verification
The assertions assume that register writes are single-cycle strobes with stable address and data, and that the pad input reflects the master's own output while the output is enabled. They also assume that the divider value is never changed in the middle of a frame, which the block itself enforces by ignoring configuration writes while busy. The bench drives the register port only at falling clock edges, resolves the pad as a pulled-up line shared with a PHY model, and has that model drive only after MDC falls and only while the master's output is disabled. Absent-device reads rely on the pull-up producing ones on the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [2:0] OFS_CMD = 3'h0;
  localparam logic [2:0] OFS_CFG = 3'h4;
  localparam int         DIV_W   = 6;
  localparam int         FRM_W   = 32;
  localparam int         DAT_W   = 16;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  // command word fields
  localparam int CMD_GO   = 29;
  localparam int CMD_FAIL = 28;
  // configuration fields
  localparam int CFG_C22  = 0;
  localparam int CFG_DIVL = 4;
  localparam int CFG_PSUP = 12;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> mdc_q);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [4:0]       phy_i,
  input  logic [4:0]       reg_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic             psup_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             run_o,
  output logic             done_o,
  output logic             rd_o,
  output logic [DAT_W-1:0] rd_word_o,
  output logic             rfail_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  localparam int POS_W = $clog2(PRE_LEN + FRM_W + 1);
  localparam logic [POS_W-1:0] PRE_P = POS_W'(PRE_LEN);
  localparam logic [POS_W-1:0] LAST  = POS_W'(PRE_LEN + FRM_W - 1);
  localparam logic [POS_W-1:0] TA1   = POS_W'(14);
  localparam logic [POS_W-1:0] TA2   = POS_W'(15);
  localparam logic [POS_W-1:0] DAT0  = POS_W'(16);

  logic             run_q, rd_q, rfail_q, mdio_q, oe_q;
  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frm_q;
  logic [DAT_W-1:0] rdat_q;
  logic             in_pre;
  logic [POS_W-1:0] rel;

  assign in_pre    = pos_q < PRE_P;
  assign rel       = pos_q - PRE_P;
  assign run_o     = run_q;
  assign rd_o      = rd_q;
  assign done_o    = run_q && rise_i && (pos_q == LAST);
  assign rd_word_o = {rdat_q[DAT_W-2:0], mdio_i};
  assign rfail_o   = rfail_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rd_q    <= 1'b0;
      rfail_q <= 1'b0;
      pos_q   <= '0;
      frm_q   <= '0;
      rdat_q  <= '0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      pos_q   <= psup_i ? PRE_P : '0;
      frm_q   <= {2'b01, op_i, phy_i, reg_i, (op_i == OP_RD) ? 2'b11 : 2'b10, wdata_i};
      rd_q    <= (op_i == OP_RD);
      rfail_q <= 1'b0;
      rdat_q  <= '0;
    end else if (run_q) begin
      if (fall_i) begin
        oe_q   <= !(rd_q && !in_pre && rel >= TA1);
        mdio_q <= in_pre ? 1'b1 : frm_q[FRM_W-1];
        if (!in_pre) frm_q <= {frm_q[FRM_W-2:0], 1'b0};
      end
      if (rise_i) begin
        if (rd_q && !in_pre) begin
          if (rel == TA2) rfail_q <= mdio_i;
          if (rel >= DAT0) rdat_q <= {rdat_q[DAT_W-2:0], mdio_i};
        end
        pos_q <= pos_q + 1'b1;
        if (pos_q == LAST) run_q <= 1'b0;
      end
    end else begin
      mdio_q <= 1'b1;
      oe_q   <= 1'b0;
    end
  end

  // R9
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !fall_i) |=> $stable(mdio_q) && $stable(oe_q));
  // R6
  oe_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $fell(oe_q)) |-> rd_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int              PRE_LEN = 32,
  parameter logic [DIV_W-1:0] RST_DIV = 6'd4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [1:0]       op_q;
  logic [4:0]       phy_q, rad_q;
  logic [DAT_W-1:0] dat_q;
  logic             fail_q, c22_q, psup_q;
  logic [DIV_W-1:0] div_q;
  logic             busy, done, rd_op, rfail, rise, fall, start, cmd_wr, cfg_wr;
  logic [DAT_W-1:0] rd_word;
  logic             unused_wdata;

  assign cmd_wr = reg_we_i && (reg_addr_i == OFS_CMD) && !busy;
  assign cfg_wr = reg_we_i && (reg_addr_i == OFS_CFG) && !busy;
  assign start  = cmd_wr && reg_wdata_i[CMD_GO];
  assign unused_wdata = ^{reg_wdata_i[31:30], reg_wdata_i[CMD_FAIL], reg_wdata_i[31:13],
                          reg_wdata_i[11:10], reg_wdata_i[3:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      phy_q  <= '0;
      rad_q  <= '0;
      dat_q  <= '0;
      fail_q <= 1'b0;
      c22_q  <= 1'b1;
      div_q  <= RST_DIV;
      psup_q <= 1'b0;
    end else begin
      if (cmd_wr) begin
        op_q  <= reg_wdata_i[27:26];
        phy_q <= reg_wdata_i[25:21];
        rad_q <= reg_wdata_i[20:16];
        dat_q <= reg_wdata_i[DAT_W-1:0];
      end
      if (start) fail_q <= 1'b0;
      if (done && rd_op) begin
        dat_q  <= rd_word;
        fail_q <= rfail;
      end
      if (cfg_wr) begin
        c22_q  <= reg_wdata_i[CFG_C22];
        div_q  <= reg_wdata_i[CFG_DIVL +: DIV_W];
        psup_q <= reg_wdata_i[CFG_PSUP];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == OFS_CMD)
      reg_rdata_o = {2'b00, busy, fail_q, op_q, phy_q, rad_q, dat_q};
    else if (reg_addr_i == OFS_CFG)
      reg_rdata_o = {19'd0, psup_q, 2'b00, div_q, 3'b000, c22_q};
  end

  mdio_mdc_gen u_mdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .div_i (div_q),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (reg_wdata_i[27:26]),
    .phy_i    (reg_wdata_i[25:21]),
    .reg_i    (reg_wdata_i[20:16]),
    .wdata_i  (reg_wdata_i[DAT_W-1:0]),
    .psup_i   (psup_q),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .run_o    (busy),
    .done_o   (done),
    .rd_o     (rd_op),
    .rd_word_o(rd_word),
    .rfail_o  (rfail),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i) |=> $stable(op_q) && $stable(phy_q) && $stable(rad_q) && $stable(div_q));
  // R5
  busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);
  // R7
  fail_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !fail_q && busy);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'h0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  int n_chk = 0, n_fail = 0, cyc = 0, rises = 0, chg_bad = 0, oe_bad = 0;

  localparam logic [4:0] PHY_ID = 5'd3;

  always #10 clk = !clk;

  mdio_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
  );

  function automatic logic [15:0] resp(input logic [4:0] r);
    return 16'hC3A5 ^ {r, 6'h00, r};
  endfunction

  // PHY model
  logic        in_frm = 1'b0, prev = 1'b1;
  int          f = 0;
  logic [11:0] hdr = '0;
  logic [1:0]  ta_seen = '0;
  logic [15:0] wr_seen = '0;

  always @(posedge mdc) begin
    rises++;
    if (!in_frm) begin
      if (!prev && mdio_line) begin in_frm = 1'b1; f = 2; end
      prev = mdio_line;
    end else begin
      if (f < 14) hdr = {hdr[10:0], mdio_line};
      else if (f < 16) ta_seen = {ta_seen[0], mdio_line};
      else begin
        wr_seen = {wr_seen[14:0], mdio_line};
        if (hdr[11:10] == 2'b10 && mdio_oe) oe_bad++;
      end
      f++;
      if (f == 32) begin in_frm = 1'b0; prev = 1'b1; phy_drv = 1'b0; end
    end
  end

  always @(negedge mdc) begin
    if (in_frm && hdr[11:10] == 2'b10 && hdr[9:5] == PHY_ID && f >= 15) begin
      phy_drv = 1'b1;
      phy_bit = (f == 15) ? 1'b0 : resp(hdr[4:0])[31-f];
    end else phy_drv = 1'b0;
  end

  // R9 monitor: output value moves only right after MDC falls
  logic p_mdio = 1'b1, p_oe = 1'b0, p_mdc = 1'b1;
  always @(negedge clk) begin
    if (p_oe && mdio_oe && (mdio_o != p_mdio) && !(p_mdc && !mdc)) chg_bad++;
    p_mdio = mdio_o; p_oe = mdio_oe; p_mdc = mdc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(3'h0, d);
      if (!d[29]) break;
    end
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] p,
                                      input logic [4:0] r, input logic [15:0] d);
    return {2'b00, 1'b1, 1'b0, op, p, r, d};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(3'h0, d); chk("R1 cmd", d, 32'h0);
    reg_rd(3'h4, d); chk("R1 cfg", d, 32'h41);
    chk("R1 mdc", {31'd0, mdc}, 32'd1);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    reg_wr(3'h4, 32'hFFFF_FFFF);
    reg_rd(3'h4, d); chk("R10 cfg mask", d, 32'h0000_13F1);
    reg_wr(3'h4, 32'h0000_0021);  // divider 2, preamble on
    reg_rd(3'h4, d); chk("R10 cfg div", d, 32'h21);
  endtask

  task automatic t_write();
    logic [31:0] d;
    realtime t0, t1;
    rises = 0;
    reg_wr(3'h0, 32'hC000_0000 | cmd(2'b01, PHY_ID, 5'd5, 16'hBEEF));
    reg_rd(3'h0, d); chk("R5 busy set", {31'd0, d[29]}, 32'd1);
    chk("R10 cmd top bits", {30'd0, d[31:30]}, 32'd0);
    @(negedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    chk("R2 period", 32'((t1 - t0) / 20.0), 32'd6);
    wait_idle();
    reg_rd(3'h0, d); chk("R5 busy clear", {31'd0, d[29]}, 32'd0);
    chk("R2 mdc idle", {31'd0, mdc}, 32'd1);
    chk("R3 rises", 32'(rises), 32'd64);
    chk("R3 header", {20'd0, hdr}, {20'd0, 2'b01, PHY_ID, 5'd5});
    chk("R3 turnaround", {30'd0, ta_seen}, 32'd2);
    chk("R3 data", {16'd0, wr_seen}, 32'h0000_BEEF);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] exp_d, input logic exp_f, input string tag);
    logic [31:0] d;
    reg_wr(3'h0, cmd(2'b10, p, r, 16'h0));
    wait_idle();
    reg_rd(3'h0, d);
    chk({tag, " data"}, {16'd0, d[15:0]}, {16'd0, exp_d});
    chk({tag, " fail"}, {31'd0, d[28]}, {31'd0, exp_f});
  endtask

  task automatic t_psup();
    logic [31:0] d;
    reg_wr(3'h4, 32'h0000_1021);
    rises = 0;
    reg_wr(3'h0, cmd(2'b01, PHY_ID, 5'd9, 16'h1234));
    wait_idle();
    chk("R4 rises", 32'(rises), 32'd32);
    chk("R4 data", {16'd0, wr_seen}, 32'h0000_1234);
    reg_rd(3'h0, d); chk("R4 fail", {31'd0, d[28]}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    rises = 0;
    reg_wr(3'h0, cmd(2'b10, PHY_ID, 5'd2, 16'h0));
    reg_wr(3'h0, cmd(2'b01, 5'd1, 5'd1, 16'h5555));
    reg_wr(3'h4, 32'h0000_0051);
    wait_idle();
    repeat (300) @(negedge clk);
    reg_rd(3'h0, d);
    chk("R8 cmd fields", {16'd0, d[27:16]}, {16'd0, 2'b10, PHY_ID, 5'd2});
    chk("R8 data", {16'd0, d[15:0]}, {16'd0, resp(5'd2)});
    chk("R8 one frame", 32'(rises), 32'd32);
    reg_rd(3'h4, d); chk("R8 cfg", d, 32'h0000_1021);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_write();
    t_read(PHY_ID, 5'd7, resp(5'd7), 1'b0, "R6 read");
    chk("R6 oe off in data", 32'(oe_bad), 32'd0);
    t_read(5'd9, 5'd1, 16'hFFFF, 1'b1, "R7 absent");
    t_read(PHY_ID, 5'd12, resp(5'd12), 1'b0, "R7 recover");
    t_psup();
    t_busy_ignore();
    chk("R9 change at fall", 32'(chg_bad), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule